// File: doc/BRIEF.md
# UART FIFO Threshold Interrupt Controller

This block holds the receive and transmit byte queues of a serial port and produces the level-based service requests for each. On the receive side a deserializer pushes bytes in and the processor pops them out. On the transmit side the processor pushes bytes and a serializer pops them. The controller compares each queue's level with a trigger level. The RX and TX requests follow different rules. It also drives a request-to-send style halt flag that tells the remote transmitter to pause when the receive queue is getting full.

All settings arrive together through one write strobe: FIFO enable, the two interrupt enables, flow-control enable, a coarse 2-bit code and a fine 4-bit field per direction, and a 4-bit halt threshold. A trigger is resolved from either its fine field or its coarse code. The controller refuses a write that would put the halt threshold below the RX trigger while flow control and RX interrupts are both on. Clearing the FIFO enable empties both queues at once.

Top module: `uart_thr_irq_top`

## Requirements
- R1: After reset, both levels are 0, rx_irq, tx_irq, rts_halt, both overrun flags and cfg_err are 0, FIFOs and all enables are off, and the halt threshold field is 15.
- R2: A trigger level is fine×4 when the direction's 4-bit fine field is nonzero. Otherwise the coarse code sets it: code 0 gives 8, code 1 gives 16, code 2 gives 56 and code 3 gives 60.
- R3: With the FIFO on and RX interrupts on, rx_irq is 1 exactly when rx_level is at or above the RX trigger, and it follows rx_level in the same cycle.
- R4: With the FIFO on and TX interrupts on, tx_irq becomes 1 one cycle after tx_level is below the TX trigger, which includes an empty queue. It becomes 0 one cycle after tx_level exceeds the trigger, and it holds its value while tx_level equals the trigger.
- R5: Each queue holds 64 bytes in first-in first-out order. A push when the queue is full is dropped, even when a pop happens in the same cycle, and it sets that queue's sticky overrun flag.
- R6: A pop reloads the data output at the next edge. A pop from an empty queue leaves the data output at the last popped byte and the level at 0.
- R7: A write with flow control on, RX interrupts on and halt×4 below the resolved RX trigger is rejected as a whole, and cfg_err becomes 1. Any accepted write sets cfg_err back to 0.
- R8: With the FIFO and flow control on, rts_halt rises one cycle after rx_level reaches halt×4. It falls one cycle after rx_level+4 drops below halt×4, and holds its value between those two points.
- R9: An accepted write with the FIFO enable at 0 zeroes both levels and both overrun flags at that edge, and sets rx_irq and tx_irq to 0. While the FIFO is off, pushes and pops have no effect.
- R10: rx_irq and tx_irq stay 0 whenever the FIFO enable or their own interrupt enable is 0, whatever the levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fifo_en | input | 1 | FIFO enable |
| cfg_rx_ie | input | 1 | RX threshold interrupt enable |
| cfg_tx_ie | input | 1 | TX threshold interrupt enable |
| cfg_flow_en | input | 1 | Receive flow-control enable |
| cfg_rx_coarse | input | 2 | RX coarse trigger code |
| cfg_tx_coarse | input | 2 | TX coarse trigger code |
| cfg_rx_fine | input | 4 | RX fine trigger field |
| cfg_tx_fine | input | 4 | TX fine trigger field |
| cfg_halt_thr | input | 4 | Halt threshold field (level = value×4) |
| rx_push | input | 1 | Deserializer byte strobe |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Processor read strobe |
| rx_dout | output | 8 | Last byte popped from RX |
| tx_push | input | 1 | Processor write strobe |
| tx_din | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Serializer fetch strobe |
| tx_dout | output | 8 | Last byte popped from TX |
| rx_level | output | 7 | RX queue occupancy |
| tx_level | output | 7 | TX queue occupancy |
| rx_irq | output | 1 | RX threshold request |
| tx_irq | output | 1 | TX threshold request |
| rts_halt | output | 1 | Flow-control halt flag |
| rx_overrun | output | 1 | Sticky RX drop flag |
| tx_overrun | output | 1 | Sticky TX drop flag |
| cfg_err | output | 1 | Last write rejected |

## Verification
A table of eight trigger settings is applied. It covers all four coarse codes, fine fields at their low, middle and top values, and a fine field set together with a coarse code, which shows that the fine field wins. For each setting the RX queue is filled to one below the trigger, then to the trigger, then popped back by one. This tells an off-by-one in the comparison apart from a wrong resolved level. Directed sequences then step the TX level through below, equal and above its trigger to expose the hysteresis. They also step the RX level across the halt and release points, overfill and drain the queue to check order and dropped pushes, send a rejected write that would otherwise flush the queues, and disable the FIFO while it holds data.

// File: rtl/uart_thr_pkg.sv
package uart_thr_pkg;
    parameter int FIFO_DEPTH = 64;
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic       fifo_en;
        logic       rx_ie;
        logic       tx_ie;
        logic       flow_en;
        logic [1:0] rx_coarse;
        logic [1:0] tx_coarse;
        logic [3:0] rx_fine;
        logic [3:0] tx_fine;
        logic [3:0] halt_thr;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        fifo_en: 1'b0, rx_ie: 1'b0, tx_ie: 1'b0, flow_en: 1'b0,
        rx_coarse: 2'd0, tx_coarse: 2'd0,
        rx_fine: 4'd0, tx_fine: 4'd0, halt_thr: 4'hF
    };

    // Fine field (x4) wins when nonzero; otherwise coarse code picks a level.
    function automatic lvl_t trig_level(input logic [3:0] fine, input logic [1:0] coarse);
        lvl_t r;
        r = lvl_t'(60);
        if (fine != 4'd0) begin
            r = lvl_t'({fine, 2'b00});
        end else begin
            case (coarse)
                2'd0: r = lvl_t'(8);
                2'd1: r = lvl_t'(16);
                2'd2: r = lvl_t'(56);
                2'd3: r = lvl_t'(60);
            endcase
        end
        return r;
    endfunction

    function automatic lvl_t halt_level(input logic [3:0] thr);
        return lvl_t'({thr, 2'b00});
    endfunction
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo
    import uart_thr_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output lvl_t          level,
    output logic          ovr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, empty, do_push, do_pop;

    assign full    = (level == lvl_t'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (do_pop) begin
            dout <= mem[rd_ptr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovr    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
            if (push && full) ovr <= 1'b1;
        end
    end

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (level == $past(level)) && ovr);
    assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
        level <= lvl_t'(DEPTH));
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> ($stable(dout) && level == '0));
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0 && !ovr));
endmodule

// File: rtl/uart_thr_cfg.sv
module uart_thr_cfg
    import uart_thr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cfg_t wr_cfg,
    output cfg_t cfg_q,
    output logic apply,
    output lvl_t rx_trig,
    output lvl_t tx_trig,
    output lvl_t halt_lvl,
    output logic cfg_err
);
    logic bad;

    // Screen: halt threshold may not sit below the RX trigger with flow + RX irq on
    assign bad   = wr_cfg.flow_en & wr_cfg.rx_ie &
                   (halt_level(wr_cfg.halt_thr) < trig_level(wr_cfg.rx_fine, wr_cfg.rx_coarse));
    assign apply = we & ~bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RST;
            cfg_err <= 1'b0;
        end else if (we) begin
            cfg_err <= bad;
            if (!bad) cfg_q <= wr_cfg;
        end
    end

    assign rx_trig  = trig_level(cfg_q.rx_fine, cfg_q.rx_coarse);
    assign tx_trig  = trig_level(cfg_q.tx_fine, cfg_q.tx_coarse);
    assign halt_lvl = halt_level(cfg_q.halt_thr);

    assert_halt_order_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.flow_en && cfg_q.rx_ie) |-> (halt_lvl >= rx_trig));
    assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (we && bad) |=> ($stable(cfg_q) && cfg_err));
endmodule

// File: rtl/uart_thr_irq.sv
module uart_thr_irq
    import uart_thr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic fifo_en,
    input  logic rx_ie,
    input  logic tx_ie,
    input  logic flow_en,
    input  lvl_t rx_trig,
    input  lvl_t tx_trig,
    input  lvl_t halt_lvl,
    input  lvl_t rx_level,
    input  lvl_t tx_level,
    output logic rx_irq,
    output logic tx_irq,
    output logic halt
);
    logic               tx_arm_q;
    logic [LVL_W:0]     rx_lvl_plus;

    assign rx_lvl_plus = {1'b0, rx_level} + (LVL_W+1)'(4);

    // TX: rearm below trigger, disarm above it, hold at equality
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tx_arm_q <= 1'b1;
        end else if (tx_level < tx_trig) begin
            tx_arm_q <= 1'b1;
        end else if (tx_level > tx_trig) begin
            tx_arm_q <= 1'b0;
        end
    end

    // Halt with 4-byte release hysteresis
    always_ff @(posedge clk) begin
        if (rst || !(fifo_en && flow_en)) begin
            halt <= 1'b0;
        end else if (rx_level >= halt_lvl) begin
            halt <= 1'b1;
        end else if (rx_lvl_plus < {1'b0, halt_lvl}) begin
            halt <= 1'b0;
        end
    end

    assign rx_irq = fifo_en & rx_ie & (rx_level >= rx_trig);
    assign tx_irq = fifo_en & tx_ie & tx_arm_q;

    assert_tx_empty_arms_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_level == '0) |=> tx_arm_q);
    assert_tx_over_disarms_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_level > tx_trig && !flush) |=> !tx_arm_q);
    assert_halt_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(halt) |-> ($past(rx_level) >= $past(halt_lvl)));
    assert_halt_fall_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(halt) && $past(fifo_en && flow_en)) |->
        (({1'b0, $past(rx_level)} + (LVL_W+1)'(4)) < {1'b0, $past(halt_lvl)}));
endmodule

// File: rtl/uart_thr_irq_top.sv
module uart_thr_irq_top
    import uart_thr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_fifo_en,
    input  logic          cfg_rx_ie,
    input  logic          cfg_tx_ie,
    input  logic          cfg_flow_en,
    input  logic [1:0]    cfg_rx_coarse,
    input  logic [1:0]    cfg_tx_coarse,
    input  logic [3:0]    cfg_rx_fine,
    input  logic [3:0]    cfg_tx_fine,
    input  logic [3:0]    cfg_halt_thr,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_din,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_dout,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_din,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_dout,
    output logic [LVL_W-1:0] rx_level,
    output logic [LVL_W-1:0] tx_level,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          rts_halt,
    output logic          rx_overrun,
    output logic          tx_overrun,
    output logic          cfg_err
);
    cfg_t wr_cfg, cfg_q;
    logic apply, flush;
    lvl_t rx_trig, tx_trig, halt_lvl;

    assign wr_cfg = '{
        fifo_en: cfg_fifo_en, rx_ie: cfg_rx_ie, tx_ie: cfg_tx_ie, flow_en: cfg_flow_en,
        rx_coarse: cfg_rx_coarse, tx_coarse: cfg_tx_coarse,
        rx_fine: cfg_rx_fine, tx_fine: cfg_tx_fine, halt_thr: cfg_halt_thr
    };

    // Queues held empty while disabled; emptied on the edge that disables them
    assign flush = ~cfg_q.fifo_en | (apply & ~cfg_fifo_en);

    uart_thr_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wr_cfg(wr_cfg), .cfg_q(cfg_q),
        .apply(apply), .rx_trig(rx_trig), .tx_trig(tx_trig),
        .halt_lvl(halt_lvl), .cfg_err(cfg_err)
    );

    uart_byte_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk(clk), .rst(rst), .flush(flush), .push(rx_push), .din(rx_din),
        .pop(rx_pop), .dout(rx_dout), .level(rx_level), .ovr(rx_overrun)
    );

    uart_byte_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk(clk), .rst(rst), .flush(flush), .push(tx_push), .din(tx_din),
        .pop(tx_pop), .dout(tx_dout), .level(tx_level), .ovr(tx_overrun)
    );

    uart_thr_irq u_irq (
        .clk(clk), .rst(rst), .flush(flush),
        .fifo_en(cfg_q.fifo_en), .rx_ie(cfg_q.rx_ie), .tx_ie(cfg_q.tx_ie),
        .flow_en(cfg_q.flow_en), .rx_trig(rx_trig), .tx_trig(tx_trig),
        .halt_lvl(halt_lvl), .rx_level(rx_level), .tx_level(tx_level),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .halt(rts_halt)
    );

    assert_gate_R10: assert property (@(posedge clk) disable iff (rst)
        $past(apply && !cfg_fifo_en) |-> (!rx_irq && !tx_irq && rx_level == '0 && tx_level == '0));
endmodule

// File: tb/uart_thr_irq_top_tb.sv
`timescale 1ns/1ps
module uart_thr_irq_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_fifo_en = 0, cfg_rx_ie = 0, cfg_tx_ie = 0, cfg_flow_en = 0;
    logic [1:0] cfg_rx_coarse = 0, cfg_tx_coarse = 0;
    logic [3:0] cfg_rx_fine = 0, cfg_tx_fine = 0, cfg_halt_thr = 4'hF;
    logic rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic [7:0] rx_din = 0, tx_din = 0;
    logic [7:0] rx_dout, tx_dout;
    logic [6:0] rx_level, tx_level;
    logic rx_irq, tx_irq, rts_halt, rx_overrun, tx_overrun, cfg_err;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    uart_thr_irq_top u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en),
        .cfg_rx_ie(cfg_rx_ie), .cfg_tx_ie(cfg_tx_ie), .cfg_flow_en(cfg_flow_en),
        .cfg_rx_coarse(cfg_rx_coarse), .cfg_tx_coarse(cfg_tx_coarse),
        .cfg_rx_fine(cfg_rx_fine), .cfg_tx_fine(cfg_tx_fine), .cfg_halt_thr(cfg_halt_thr),
        .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
        .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
        .rx_level(rx_level), .tx_level(tx_level), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .rts_halt(rts_halt), .rx_overrun(rx_overrun), .tx_overrun(tx_overrun),
        .cfg_err(cfg_err)
    );

    // {fine[3:0], coarse[1:0], expected trigger[6:0]}
    localparam logic [12:0] TRIG_VEC [8] = '{
        {4'd0,  2'd0, 7'd8},
        {4'd0,  2'd1, 7'd16},
        {4'd0,  2'd2, 7'd56},
        {4'd0,  2'd3, 7'd60},
        {4'd1,  2'd3, 7'd4},
        {4'd5,  2'd2, 7'd20},
        {4'd15, 2'd0, 7'd60},
        {4'd3,  2'd1, 7'd12}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic rie, input logic tie, input logic flow,
                             input logic [1:0] rc, input logic [1:0] tc,
                             input logic [3:0] rf, input logic [3:0] tf, input logic [3:0] ht);
        cfg_fifo_en = en; cfg_rx_ie = rie; cfg_tx_ie = tie; cfg_flow_en = flow;
        cfg_rx_coarse = rc; cfg_tx_coarse = tc; cfg_rx_fine = rf; cfg_tx_fine = tf;
        cfg_halt_thr = ht; cfg_we = 1;
        step();
        cfg_we = 0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_din = d; rx_push = 1; step(); rx_push = 0;
    endtask
    task automatic pop_rx();
        rx_pop = 1; step(); rx_pop = 0;
    endtask
    task automatic push_tx(input logic [7:0] d);
        tx_din = d; tx_push = 1; step(); tx_push = 0;
    endtask
    task automatic pop_tx();
        tx_pop = 1; step(); tx_pop = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] exp_t;
        repeat (3) step();
        rst = 0;
        step();
        // R1 reset state
        check("R1 rx_level", rx_level, 0);
        check("R1 tx_level", tx_level, 0);
        check("R1 irqs", {rx_irq, tx_irq, rts_halt}, 0);
        check("R1 flags", {rx_overrun, tx_overrun, cfg_err}, 0);

        // R2/R3 table walk
        for (int i = 0; i < 8; i++) begin
            exp_t = TRIG_VEC[i][6:0];
            write_cfg(0, 0, 0, 0, 0, 0, 0, 0, 4'hF);
            write_cfg(1, 1, 0, 0, TRIG_VEC[i][8:7], 0, TRIG_VEC[i][12:9], 0, 4'hF);
            for (int k = 0; k < exp_t - 1; k++) push_rx(8'(k));
            check("R3 below trigger", rx_irq, 0);
            push_rx(8'hA5);
            check("R2 trigger reached", rx_irq, 1);
            pop_rx();
            check("R3 back below trigger", rx_irq, 0);
        end

        // R10 gating by interrupt enables
        write_cfg(0, 0, 0, 0, 0, 0, 0, 0, 4'hF);
        write_cfg(1, 0, 0, 0, 0, 0, 0, 0, 4'hF);
        for (int k = 0; k < 8; k++) push_rx(8'(k));
        step();
        check("R10 rx gated", rx_irq, 0);
        check("R10 tx gated", tx_irq, 0);
        write_cfg(1, 1, 1, 0, 0, 0, 0, 0, 4'hF);
        check("R10 rx enabled", rx_irq, 1);
        check("R10 tx enabled", tx_irq, 1);

        // R4 TX hysteresis, trigger 8
        for (int k = 0; k < 8; k++) push_tx(8'(k));
        step();
        check("R4 equal holds high", tx_irq, 1);
        push_tx(8'h08);
        step();
        check("R4 above trigger low", tx_irq, 0);
        pop_tx();
        step();
        check("R4 equal holds low", tx_irq, 0);
        pop_tx();
        step();
        check("R4 below trigger high", tx_irq, 1);

        // R5/R6 depth, order, overrun, empty pop
        write_cfg(0, 0, 0, 0, 0, 0, 0, 0, 4'hF);
        write_cfg(1, 0, 0, 0, 0, 0, 0, 0, 4'hF);
        for (int k = 0; k < 64; k++) push_rx(8'(k * 3));
        check("R5 full level", rx_level, 64);
        check("R5 no overrun yet", rx_overrun, 0);
        rx_din = 8'hEE; rx_push = 1; rx_pop = 1; step(); rx_push = 0; rx_pop = 0;
        check("R5 push on full dropped", rx_level, 63);
        check("R5 overrun set", rx_overrun, 1);
        check("R5 first out", rx_dout, 0);
        for (int k = 1; k < 64; k++) begin
            pop_rx();
            check("R5 order", rx_dout, (k * 3) & 8'hFF);
        end
        check("R5 overrun sticky", rx_overrun, 1);
        pop_rx();
        check("R6 empty pop data", rx_dout, (63 * 3) & 8'hFF);
        check("R6 empty pop level", rx_level, 0);
        write_cfg(0, 0, 0, 0, 0, 0, 0, 0, 4'hF);
        check("R9 overrun cleared", rx_overrun, 0);

        // R7 rejected write must not flush
        write_cfg(1, 0, 0, 0, 0, 0, 0, 0, 4'hF);
        for (int k = 0; k < 5; k++) push_rx(8'(k));
        write_cfg(0, 1, 0, 1, 2'd3, 0, 0, 0, 4'd14);
        check("R7 error flagged", cfg_err, 1);
        check("R7 write not applied", rx_level, 5);
        write_cfg(1, 1, 0, 1, 0, 0, 4'd2, 0, 4'd4);
        check("R7 error cleared", cfg_err, 0);

        // R8 halt with hysteresis, halt level 16
        write_cfg(0, 0, 0, 0, 0, 0, 0, 0, 4'hF);
        write_cfg(1, 1, 0, 1, 0, 0, 4'd2, 0, 4'd4);
        for (int k = 0; k < 15; k++) push_rx(8'(k));
        step();
        check("R8 below halt", rts_halt, 0);
        push_rx(8'h10);
        step();
        check("R8 halt rises", rts_halt, 1);
        for (int k = 0; k < 4; k++) pop_rx();
        step();
        check("R8 halt held at 12", rts_halt, 1);
        pop_rx();
        step();
        check("R8 halt released at 11", rts_halt, 0);

        // R9 disable with data present
        write_cfg(1, 1, 1, 0, 0, 0, 0, 0, 4'hF);
        for (int k = 0; k < 10; k++) push_tx(8'(k));
        check("R9 rx irq before", rx_irq, 1);
        write_cfg(0, 1, 1, 0, 0, 0, 0, 0, 4'hF);
        check("R9 rx level zero", rx_level, 0);
        check("R9 tx level zero", tx_level, 0);
        check("R9 irqs low", {rx_irq, tx_irq}, 0);
        push_rx(8'h55);
        push_tx(8'h66);
        check("R9 push ignored rx", rx_level, 0);
        check("R9 push ignored tx", tx_level, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule